// File: doc/BRIEF.md
# Active Priority Tracker

This block keeps a record of which priority levels are currently in service for two interrupt groups (group 0 and group 1). Every time an interrupt is taken, its priority is folded down to one of the implemented levels. The bit for that level is then set in the bitmap of the interrupt's group. A priority drop retires the most urgent level that is still active.

The block continuously reports the running priority, which is the most urgent active level re-expanded to an 8-bit priority value. It also reports the group that owns that level, and a flag that is set when nothing is active. Lower numeric priority is more urgent. The number of implemented priority bits is a parameter between 5 and 8. The value 0xFF on the priority output means idle.

The most urgent level is found in two steps. First, each 32-level word of the two bitmaps is searched for its lowest set bit. Then the words are compared in ascending order. The first word that holds any set bit decides the result. Within that word, group 0 takes precedence when both groups have the same lowest level.

Top module: `active_prio_tracker`

## Requirements
- R1: After reset, `run_idle` is 1, `run_prio` is 0xFF and `run_grp` is 0.
- R2: An activation maps `act_prio` to level `act_prio >> (8 - PRIO_BITS)` and marks that level active in the bitmap of `act_grp` (0 = group 0, 1 = group 1). Priorities that differ only in the discarded low bits share a level.
- R3: When some level is active, `run_prio` equals the most urgent level shifted left by `(8 - PRIO_BITS)`, so its low `8 - PRIO_BITS` bits are zero. The outputs reflect an operation from the clock cycle that follows its sampling edge.
- R4: The lowest-numbered active level across both groups decides `run_prio`, regardless of which 32-level word it lies in. `run_grp` names the group that owns that level.
- R5: When both groups have the same lowest active level, `run_grp` reports group 0.
- R6: A drop clears the running level only in the bitmap of the group that owns it. The same level held by the other group stays active.
- R7: A drop while idle changes nothing.
- R8: When an activation and a drop arrive in the same cycle, the drop retires the level that was running before the edge, and then the activation is applied. Re-activating the dropped level in that cycle leaves it active.
- R9: Activating a level that is already active in the same group has no further effect, so a single drop retires it.
- R10: When no level is active, `run_prio` is 0xFF, `run_grp` is 0 and `run_idle` is 1. With `PRIO_BITS = 8`, `run_idle` is the only way to tell idle apart from active level 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activate the priority on `act_prio` for group `act_grp` |
| act_prio | input | 8 | Priority of the interrupt being activated |
| act_grp | input | 1 | Group of the activation (0 or 1) |
| drop_valid | input | 1 | Retire the running priority level |
| run_prio | output | 8 | Running priority, 0xFF when idle |
| run_grp | output | 1 | Group owning the running level, 0 when idle |
| run_idle | output | 1 | No level active |

## Verification
The hardest case to reach is a drop and an activation landing in the same cycle while both groups hold the same level. In that case, the ordering of clear-then-set and the group-0 tie rule both affect the result. Directed sequences first build a shared level in both groups, then drop and re-activate it in a single cycle. A long random walk then interleaves activations across all four words with drops, including drops at idle. A reference bitmap model in the bench predicts each cycle's outputs.

// File: rtl/apt_pkg.sv
package apt_pkg;

  localparam int WORD_BITS = 32;

  typedef struct packed {
    logic       hit;
    logic       grp;
    logic [4:0] bit_idx;
  } word_pick_t;

  // Index of lowest set bit, 32 when the word is empty.
  function automatic logic [5:0] ctz32(input logic [31:0] w);
    logic [5:0] r;
    r = 6'd32;
    for (int i = 31; i >= 0; i--) begin
      if (w[i]) r = 6'(i);
    end
    return r;
  endfunction

  function automatic logic [7:0] level_of(input logic [7:0] prio, input int shift);
    return prio >> shift;
  endfunction

  function automatic logic [7:0] prio_of(input logic [7:0] lvl, input int shift);
    return lvl << shift;
  endfunction

endpackage

// File: rtl/apt_word_pick.sv
module apt_word_pick
  import apt_pkg::*;
(
  input  logic [31:0] g0_word,
  input  logic [31:0] g1_word,
  output word_pick_t  pick
);

  logic [5:0] tz0;
  logic [5:0] tz1;
  logic       g1_wins;

  assign tz0     = ctz32(g0_word);
  assign tz1     = ctz32(g1_word);
  // group 0 keeps ties
  assign g1_wins = tz1 < tz0;

  always_comb begin
    pick.hit     = (|g0_word) | (|g1_word);
    pick.grp     = g1_wins;
    pick.bit_idx = g1_wins ? tz1[4:0] : tz0[4:0];
  end

endmodule

// File: rtl/apt_bank.sv
module apt_bank #(
  parameter int LEVELS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [7:0]        set_idx,
  input  logic              clr_en,
  input  logic [7:0]        clr_idx,
  output logic [LEVELS-1:0] map_q
);

  localparam logic [LEVELS-1:0] ONE = {{(LEVELS-1){1'b0}}, 1'b1};

  logic [LEVELS-1:0] set_mask;
  logic [LEVELS-1:0] clr_mask;
  logic [LEVELS-1:0] map_d;

  assign set_mask = set_en ? (ONE << set_idx) : '0;
  assign clr_mask = clr_en ? (ONE << clr_idx) : '0;
  // clear first, then set
  assign map_d    = (map_q & ~clr_mask) | set_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  // R2
  bank_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> (map_q & $past(set_mask)) != '0);

  // R6
  bank_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(set_en && set_idx == clr_idx)) |=> (map_q & $past(clr_mask)) == '0);

endmodule

// File: rtl/active_prio_tracker.sv
module active_prio_tracker
  import apt_pkg::*;
#(
  parameter int PRIO_BITS = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       act_valid,
  input  logic [7:0] act_prio,
  input  logic       act_grp,
  input  logic       drop_valid,
  output logic [7:0] run_prio,
  output logic       run_grp,
  output logic       run_idle
);

  localparam int SHIFT  = 8 - PRIO_BITS;
  localparam int LEVELS = 1 << PRIO_BITS;
  localparam int NWORDS = LEVELS / WORD_BITS;
  localparam logic [7:0] LOW_MASK = 8'((1 << SHIFT) - 1);

  logic [LEVELS-1:0] grp_map [2];
  word_pick_t        picks [NWORDS];

  logic [7:0] act_lvl;
  logic [7:0] run_lvl;
  logic       any_active;
  logic       top_grp;
  logic       drop_fire;

  assign act_lvl   = level_of(act_prio, SHIFT);
  assign drop_fire = drop_valid && any_active;

  for (genvar g = 0; g < 2; g++) begin : g_bank
    apt_bank #(.LEVELS(LEVELS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_en  (act_valid && (act_grp == 1'(g))),
      .set_idx (act_lvl),
      .clr_en  (drop_fire && (top_grp == 1'(g))),
      .clr_idx (run_lvl),
      .map_q   (grp_map[g])
    );
  end

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    apt_word_pick u_pick (
      .g0_word (grp_map[0][w*WORD_BITS +: WORD_BITS]),
      .g1_word (grp_map[1][w*WORD_BITS +: WORD_BITS]),
      .pick    (picks[w])
    );
  end

  // scan from the top down so the lowest nonzero word is applied last
  always_comb begin
    any_active = 1'b0;
    top_grp    = 1'b0;
    run_lvl    = '0;
    for (int w = NWORDS - 1; w >= 0; w--) begin
      if (picks[w].hit) begin
        any_active = 1'b1;
        top_grp    = picks[w].grp;
        run_lvl    = 8'(w * WORD_BITS) | {3'b000, picks[w].bit_idx};
      end
    end
  end

  assign run_idle = !any_active;
  assign run_grp  = any_active && top_grp;
  assign run_prio = any_active ? prio_of(run_lvl, SHIFT) : 8'hFF;

  // R3
  low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_idle |-> (run_prio & LOW_MASK) == 8'h00);

  // R4
  act_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid |=> (!run_idle && run_prio <= $past(act_prio & ~LOW_MASK)));

  // R6
  drop_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_valid && !act_valid && !run_idle) |=> (run_idle || run_prio >= $past(run_prio)));

  // R7
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_idle && drop_valid && !act_valid) |=> run_idle);

  // R10
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_idle |-> (run_prio == 8'hFF && !run_grp));

endmodule

// File: tb/active_prio_tracker_tb.sv
module active_prio_tracker_tb;

  localparam int PERIOD = 10;
  localparam int NLVL   = 128;
  localparam int SH     = 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       act_valid = 1'b0;
  logic [7:0] act_prio = 8'h00;
  logic       act_grp = 1'b0;
  logic       drop_valid = 1'b0;
  logic [7:0] run_prio;
  logic       run_grp;
  logic       run_idle;

  int  total = 0;
  int  bad = 0;
  bit  done = 1'b0;

  bit m0 [NLVL];
  bit m1 [NLVL];

  logic [7:0] q_prio [$];
  logic       q_grp  [$];
  logic       q_idle [$];
  string      q_tag  [$];

  always #(PERIOD/2) clk = ~clk;

  active_prio_tracker u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_valid  (act_valid),
    .act_prio   (act_prio),
    .act_grp    (act_grp),
    .drop_valid (drop_valid),
    .run_prio   (run_prio),
    .run_grp    (run_grp),
    .run_idle   (run_idle)
  );

  task automatic best(output bit hit, output int lvl, output bit grp);
    hit = 0; lvl = 0; grp = 0;
    for (int l = 0; l < NLVL; l++) begin
      if (!hit && m0[l]) begin hit = 1; lvl = l; grp = 0; end
      else if (!hit && m1[l]) begin hit = 1; lvl = l; grp = 1; end
    end
  endtask

  task automatic op(input bit a, input logic [7:0] p, input bit g, input bit d, input string tag);
    bit hit; int lvl; bit grp;
    @(negedge clk);
    act_valid = a; act_prio = p; act_grp = g; drop_valid = d;
    best(hit, lvl, grp);
    if (d && hit) begin
      if (grp) m1[lvl] = 0; else m0[lvl] = 0;
    end
    if (a) begin
      if (g) m1[int'(p) >> SH] = 1; else m0[int'(p) >> SH] = 1;
    end
    best(hit, lvl, grp);
    q_prio.push_back(hit ? 8'(lvl << SH) : 8'hFF);
    q_grp.push_back(hit ? grp : 1'b0);
    q_idle.push_back(!hit);
    q_tag.push_back(tag);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (q_prio.size() > 0) begin
        logic [7:0] ep; logic eg; logic ei; string t;
        ep = q_prio.pop_front(); eg = q_grp.pop_front();
        ei = q_idle.pop_front(); t = q_tag.pop_front();
        total++;
        if (run_prio !== ep || run_grp !== eg || run_idle !== ei) begin
          bad++;
          $display("FAIL %s actual prio=%h grp=%0d idle=%0d expected prio=%h grp=%0d idle=%0d",
                   t, run_prio, run_grp, run_idle, ep, eg, ei);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #(PERIOD/4);
    total++;
    // R1 reset state
    if (run_prio !== 8'hFF || run_grp !== 1'b0 || run_idle !== 1'b1) begin
      bad++;
      $display("FAIL R1 actual prio=%h grp=%0d idle=%0d expected prio=ff grp=0 idle=1",
               run_prio, run_grp, run_idle);
    end
    @(negedge clk); rst_n = 1'b1;

    // R2 R3: 0x41 folds to level 32, shown as 0x40
    op(1, 8'h41, 1, 0, "R2 R3 fold");
    // R5 tie at same level
    op(1, 8'h40, 0, 0, "R5 tie");
    // R6 drop clears only owner
    op(0, 8'h00, 0, 1, "R6 owner only");
    op(0, 8'h00, 0, 1, "R10 idle after drop");
    // R7 drop at idle
    op(0, 8'h00, 0, 1, "R7 idle drop");
    op(0, 8'h00, 0, 1, "R7 idle drop again");
    op(1, 8'hA0, 0, 0, "R7 after idle drop");
    op(0, 8'h00, 0, 1, "R10 back idle");
    // R4 across words
    op(1, 8'hF0, 1, 0, "R4 word3");
    op(1, 8'h90, 0, 0, "R4 word2");
    op(1, 8'h22, 1, 0, "R4 word0");
    op(0, 8'h00, 0, 1, "R4 drop to word2");
    op(0, 8'h00, 0, 1, "R4 drop to word3");
    op(0, 8'h00, 0, 1, "R10 empty");
    // R9 repeated activation
    op(1, 8'h10, 0, 0, "R9 first");
    op(1, 8'h11, 0, 0, "R9 again");
    op(0, 8'h00, 0, 1, "R9 single drop");
    // R8 same-cycle activate and drop
    op(1, 8'h30, 0, 0, "R8 setup");
    op(1, 8'h50, 1, 1, "R8 drop old set new");
    op(1, 8'h50, 1, 1, "R8 reactivate same level");
    op(0, 8'h00, 0, 1, "R8 drain");
    // R8 with shared level in both groups
    op(1, 8'h60, 0, 0, "R8 shared g0");
    op(1, 8'h60, 1, 0, "R8 shared g1");
    op(1, 8'h60, 0, 1, "R8 R5 shared drop and set");
    op(0, 8'h00, 0, 1, "R6 shared drop");
    op(0, 8'h00, 0, 1, "R6 shared drop2");
    // R2 R3 extremes
    op(1, 8'h07, 0, 0, "R3 low bit cleared");
    op(1, 8'h00, 1, 0, "R2 top level");
    op(1, 8'hFF, 0, 0, "R2 bottom level");
    op(0, 8'h00, 0, 1, "R3 drain1");
    op(0, 8'h00, 0, 1, "R3 drain2");
    op(0, 8'h00, 0, 1, "R3 drain3");
    op(0, 8'h00, 0, 1, "R10 empty again");

    // random walk
    for (int i = 0; i < 400; i++) begin
      op(($urandom % 3) != 0, 8'($urandom), 1'($urandom), ($urandom % 2) == 0, "R4 random");
    end
    for (int i = 0; i < 140; i++) op(0, 8'h00, 0, 1, "R6 random drain");

    op(0, 8'h00, 0, 0, "R10 final");
    while (q_prio.size() > 0) @(posedge clk);
    #(PERIOD);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule